// File: doc/BRIEF.md
# Packed Decimal Add/Subtract Unit

This block adds or subtracts two signed packed-decimal operands of 128 bits each. Every operand carries 31 decimal digits in its upper 124 bits, one digit per nibble with the most significant digit at the top. The least significant nibble holds the sign code. The unit works in signed magnitude. For a subtraction it first flips the sign of B. Operands of the same sign have their magnitudes added. Operands of opposite sign have the smaller magnitude taken from the larger, and the result takes the sign of the larger operand.

The stored result keeps only 31 digits. The 4-bit condition field describes the exact, untruncated result, so a positive result whose stored digits wrap to zero still reports positive with overflow. A preferred-sign input selects which code marks a positive or zero result. Any digit nibble above 9 raises an invalid flag.

The unit is registered. A strobe on `in_valid` captures the operation, and the result appears on the next cycle with `out_valid` high. A two-state machine sequences this. ST_IDLE moves to ST_OUT on a strobe. ST_OUT stays in ST_OUT on another strobe and returns to ST_IDLE when no strobe is present.

Top module: `bcd_addsub_unit`

## Requirements
- R1: `out_valid` is 0 after reset. It is 1 in the cycle after each cycle in which `in_valid` was 1, and 0 otherwise. Outputs are captured at the clock edge where `in_valid` is 1.
- R2: When the effective signs match, the result magnitude is the sum of the magnitudes and the result takes the common sign.
- R3: When `sub` is 1, the unit computes A minus B by inverting the sign of B before the signed-magnitude add.
- R4: When the effective signs differ, the result magnitude is the larger magnitude minus the smaller one, and the result takes the sign of the larger operand.
- R5: A negative result is written with sign code 0xD. A positive result is written with 0xC when `pref_sign` is 0 and with 0xF when `pref_sign` is 1.
- R6: A zero result is written with all digits 0 and the positive code chosen by `pref_sign`. The condition field is then 4'b0010. This includes the sum of two negative zeros.
- R7: Overflow occurs when the exact magnitude needs more than 31 digits. The stored digits are then the low 31 digits of that magnitude, and bit 0 of the condition field is set. The sign bits come from the exact result, so the largest positive value minus negative one gives all-zero digits, sign 0xC and condition 4'b0101.
- R8: On input, sign codes 0xB and 0xD mean negative. Every other code, including 0xA, 0xC, 0xE and 0xF, means positive.
- R9: If any digit nibble of A or B is above 9, `invalid` is 1 and the condition field is 4'b0001.
- R10: For a valid operation the condition field is {LT, GT, EQ, OV}, bits 3 down to 0. Exactly one of bits 3 to 1 is set: 4'b1000 for negative, 4'b0100 for positive and 4'b0010 for zero, with OV in bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operation strobe |
| op_a | input | 128 | Operand A: 31 digits plus a sign nibble |
| op_b | input | 128 | Operand B: 31 digits plus a sign nibble |
| sub | input | 1 | 1 selects A minus B, 0 selects A plus B |
| pref_sign | input | 1 | Positive sign code select: 0 gives 0xC, 1 gives 0xF |
| out_valid | output | 1 | Result valid |
| result | output | 128 | Result: 31 digits plus a sign nibble |
| cond | output | 4 | Condition field {LT, GT, EQ, OV} |
| invalid | output | 1 | A digit nibble above 9 was seen |

## Verification
The add path is tried with operands of matching signs and of opposite signs, where the larger magnitude sits in A in some tests and in B in others. This shows whether the result sign follows the larger magnitude rather than a fixed operand. Subtractions cover both signs of B, which separates a correct sign inversion from a plain add. Equal magnitudes and two negative zeros probe the zero path and its sign code. Sums and differences at the largest 31-digit values separate a condition field taken from the exact result from one taken from the truncated digits. Every result is compared with a model that does integer arithmetic on the decimal values.

// File: rtl/bcd_pkg.sv
package bcd_pkg;
    typedef enum logic [0:0] {ST_IDLE, ST_OUT} bcd_state_t;

    localparam logic [3:0] SGN_POS_STD = 4'hC;
    localparam logic [3:0] SGN_POS_ALT = 4'hF;
    localparam logic [3:0] SGN_NEG     = 4'hD;
    localparam logic [3:0] COND_INVAL  = 4'b0001;

    function automatic logic sign_is_neg(input logic [3:0] code);
        return (code == 4'hB) || (code == 4'hD);
    endfunction
endpackage

// File: rtl/bcd_digit_chain.sv
module bcd_digit_chain #(
    parameter int NDIG = 31,
    parameter bit SUB  = 1'b0,
    localparam int MW  = 4 * NDIG
) (
    input  logic [MW-1:0] x,
    input  logic [MW-1:0] y,
    output logic [MW-1:0] z,
    output logic          cout
);
    logic [NDIG:0] c;
    assign c[0] = 1'b0;
    assign cout = c[NDIG];

    for (genvar i = 0; i < NDIG; i++) begin : g_dig
        logic [4:0] t;
        if (SUB) begin : g_sub
            always_comb begin
                t = {1'b0, x[4*i +: 4]} - {1'b0, y[4*i +: 4]} - {4'd0, c[i]};
                if (t[4]) begin
                    z[4*i +: 4] = 4'(t + 5'd10);
                    c[i+1]      = 1'b1;
                end else begin
                    z[4*i +: 4] = t[3:0];
                    c[i+1]      = 1'b0;
                end
            end
        end else begin : g_add
            always_comb begin
                t = {1'b0, x[4*i +: 4]} + {1'b0, y[4*i +: 4]} + {4'd0, c[i]};
                if (t > 5'd9) begin
                    z[4*i +: 4] = 4'(t - 5'd10);
                    c[i+1]      = 1'b1;
                end else begin
                    z[4*i +: 4] = t[3:0];
                    c[i+1]      = 1'b0;
                end
            end
        end
    end
endmodule

// File: rtl/bcd_digit_check.sv
module bcd_digit_check #(
    parameter int NDIG = 31,
    localparam int MW  = 4 * NDIG
) (
    input  logic [MW-1:0] digits,
    output logic          bad
);
    logic [NDIG-1:0] over;
    for (genvar i = 0; i < NDIG; i++) begin : g_chk
        assign over[i] = digits[4*i +: 4] > 4'd9;
    end
    assign bad = |over;
endmodule

// File: rtl/bcd_addsub_unit.sv
module bcd_addsub_unit
    import bcd_pkg::*;
#(
    parameter int NDIG = 31,
    localparam int MW  = 4 * NDIG,
    localparam int W   = MW + 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_valid,
    input  logic [W-1:0] op_a,
    input  logic [W-1:0] op_b,
    input  logic         sub,
    input  logic         pref_sign,
    output logic         out_valid,
    output logic [W-1:0] result,
    output logic [3:0]   cond,
    output logic         invalid
);
    bcd_state_t state, state_nx;

    logic [MW-1:0] a_mag, b_mag;
    logic          a_neg, b_neg;
    logic [MW-1:0] sum_d, dab_d, dba_d;
    logic          sum_c, dab_b, dba_b;
    logic          a_bad, b_bad;

    assign a_mag = op_a[W-1:4];
    assign b_mag = op_b[W-1:4];
    assign a_neg = sign_is_neg(op_a[3:0]);
    assign b_neg = sign_is_neg(op_b[3:0]) ^ sub;

    bcd_digit_chain #(.NDIG(NDIG), .SUB(1'b0)) u_add (.x(a_mag), .y(b_mag), .z(sum_d), .cout(sum_c));
    bcd_digit_chain #(.NDIG(NDIG), .SUB(1'b1)) u_dab (.x(a_mag), .y(b_mag), .z(dab_d), .cout(dab_b));
    bcd_digit_chain #(.NDIG(NDIG), .SUB(1'b1)) u_dba (.x(b_mag), .y(a_mag), .z(dba_d), .cout(dba_b));
    bcd_digit_check #(.NDIG(NDIG)) u_cka (.digits(a_mag), .bad(a_bad));
    bcd_digit_check #(.NDIG(NDIG)) u_ckb (.digits(b_mag), .bad(b_bad));

    logic [MW-1:0] mag;
    logic          neg, nonzero, ovf, bad;
    logic [3:0]    sgn_code, cond_nx;

    always_comb begin
        if (a_neg == b_neg) begin
            mag     = sum_d;
            ovf     = sum_c;
            neg     = a_neg;
            nonzero = (sum_d != '0) || sum_c;
        end else if (!dab_b) begin
            mag     = dab_d;
            ovf     = 1'b0;
            neg     = a_neg;
            nonzero = (dab_d != '0);
        end else begin
            mag     = dba_d;
            ovf     = 1'b0;
            neg     = b_neg;
            nonzero = 1'b1;
        end
        if (!nonzero) neg = 1'b0;
        bad      = a_bad || b_bad;
        sgn_code = neg ? SGN_NEG : (pref_sign ? SGN_POS_ALT : SGN_POS_STD);
        cond_nx  = bad ? COND_INVAL : {neg, !neg && nonzero, !nonzero, ovf};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (in_valid)  state_nx = ST_OUT;
            ST_OUT:  if (!in_valid) state_nx = ST_IDLE;
            default: state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result  <= '0;
            cond    <= '0;
            invalid <= 1'b0;
        end else if (in_valid) begin
            result  <= {mag, sgn_code};
            cond    <= cond_nx;
            invalid <= bad;
        end
    end

    assign out_valid = (state == ST_OUT);
endmodule

// File: rtl/bcd_addsub_chk.sv
module bcd_addsub_chk #(
    parameter int NDIG = 31,
    localparam int W   = 4 * NDIG + 4
) (
    input logic         clk,
    input logic         rst_n,
    input logic         in_valid,
    input logic         pref_sign,
    input logic         out_valid,
    input logic [W-1:0] result,
    input logic [3:0]   cond,
    input logic         invalid
);
    a_r1_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    a_r1_valid_drops: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    a_r9_invalid_cond: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && invalid) |-> cond == 4'b0001);
    a_r10_one_relation: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !invalid) |-> $countones(cond[3:1]) == 1);
    a_r5_neg_code: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !invalid && cond[3]) |-> result[3:0] == 4'hD);
    a_r5_pos_code: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !invalid && cond[2]) |-> result[3:0] == ($past(pref_sign) ? 4'hF : 4'hC));
    a_r6_zero_form: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !invalid && cond[1]) |-> (result[W-1:4] == '0 && !cond[0]));
endmodule

bind bcd_addsub_unit bcd_addsub_chk #(.NDIG(NDIG)) u_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .pref_sign(pref_sign),
    .out_valid(out_valid), .result(result), .cond(cond), .invalid(invalid)
);

// File: tb/sim_bcd_addsub_unit.sv
module sim_bcd_addsub_unit;
    localparam int CLK_PERIOD = 10;
    localparam int NDIG = 31;

    logic         clk = 1'b0, rst_n = 1'b0, in_valid = 1'b0, sub = 1'b0, pref_sign = 1'b0;
    logic [127:0] op_a = '0, op_b = '0;
    logic         out_valid, invalid;
    logic [127:0] result;
    logic [3:0]   cond;
    int checks = 0, errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    bcd_addsub_unit u0 (.clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_a(op_a), .op_b(op_b),
        .sub(sub), .pref_sign(pref_sign), .out_valid(out_valid), .result(result),
        .cond(cond), .invalid(invalid));

    task automatic check(input string tag, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic signed [127:0] lim();
        logic signed [127:0] p = 1;
        for (int i = 0; i < NDIG; i++) p = p * 10;
        return p;
    endfunction

    function automatic logic signed [127:0] to_int(input logic [127:0] v);
        logic signed [127:0] m = 0;
        for (int i = NDIG; i >= 1; i--) m = m * 10 + v[4*i +: 4];
        if (v[3:0] == 4'hB || v[3:0] == 4'hD) m = -m;
        return m;
    endfunction

    function automatic logic [127:0] mk(input logic signed [127:0] mag, input logic [3:0] sgn);
        logic [127:0] r = '0;
        logic signed [127:0] m = mag;
        r[3:0] = sgn;
        for (int i = 1; i <= NDIG; i++) begin
            r[4*i +: 4] = 4'(m % 10);
            m = m / 10;
        end
        return r;
    endfunction

    task automatic run(input string tag, input logic [127:0] a, input logic [127:0] b,
                       input logic s, input logic p);
        logic signed [127:0] va, vb, r, m;
        logic [3:0] ec;
        logic ov;
        va = to_int(a);
        vb = to_int(b);
        r  = s ? va - vb : va + vb;
        m  = (r < 0) ? -r : r;
        ov = m >= lim();
        ec = (r < 0) ? 4'b1000 : (r > 0) ? 4'b0100 : 4'b0010;
        ec[0] = ov;
        @(negedge clk);
        op_a = a; op_b = b; sub = s; pref_sign = p; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        check({tag, " out_valid R1"}, 128'(out_valid), 128'd1);
        check({tag, " result"}, result,
              mk(m % lim(), (r < 0) ? 4'hD : (p ? 4'hF : 4'hC)));
        check({tag, " cond R10"}, 128'(cond), 128'(ec));
        check({tag, " invalid"}, 128'(invalid), 128'd0);
    endtask

    task automatic t_reset();
        check("R1 reset out_valid", 128'(out_valid), 128'd0);
        check("R1 reset cond", 128'(cond), 128'd0);
    endtask

    task automatic t_like();
        run("R2 pos+pos", mk(123, 4'hC), mk(456, 4'hC), 1'b0, 1'b0);
        run("R2 neg+neg", mk(5, 4'hD), mk(7, 4'hD), 1'b0, 1'b0);
    endtask

    task automatic t_unlike();
        run("R4 larger B", mk(100, 4'hC), mk(250, 4'hD), 1'b0, 1'b0);
        run("R4 larger A", mk(250, 4'hC), mk(100, 4'hD), 1'b0, 1'b0);
        run("R4 neg A larger", mk(900, 4'hD), mk(1, 4'hC), 1'b0, 1'b0);
    endtask

    task automatic t_sub();
        run("R3 pos-pos", mk(50, 4'hC), mk(80, 4'hC), 1'b1, 1'b0);
        run("R3 pos-neg", mk(7, 4'hC), mk(3, 4'hD), 1'b1, 1'b0);
        run("R3 neg-neg", mk(7, 4'hD), mk(9, 4'hD), 1'b1, 1'b0);
    endtask

    task automatic t_pref();
        run("R5 pref positive F", mk(11, 4'hC), mk(22, 4'hC), 1'b0, 1'b1);
        run("R5 negative D with pref", mk(11, 4'hC), mk(22, 4'hC), 1'b1, 1'b1);
    endtask

    task automatic t_zero();
        run("R6 equal diff", mk(42, 4'hC), mk(42, 4'hC), 1'b1, 1'b0);
        run("R6 neg zeros pref", mk(0, 4'hD), mk(0, 4'hD), 1'b0, 1'b1);
        run("R6 x+(-x)", mk(987654, 4'hD), mk(987654, 4'hC), 1'b0, 1'b0);
    endtask

    task automatic t_overflow();
        logic signed [127:0] mx = lim() - 1;
        run("R7 max+1", mk(mx, 4'hC), mk(1, 4'hC), 1'b0, 1'b0);
        run("R7 max-(-1)", mk(mx, 4'hC), mk(1, 4'hD), 1'b1, 1'b0);
        run("R7 -max+-max", mk(mx, 4'hD), mk(mx, 4'hD), 1'b0, 1'b0);
        run("R7 max-max", mk(mx, 4'hC), mk(mx, 4'hC), 1'b1, 1'b1);
        run("R7 max+0 no ov", mk(mx, 4'hC), mk(0, 4'hC), 1'b0, 1'b0);
    endtask

    task automatic t_codes();
        run("R8 A and B codes", mk(30, 4'hA), mk(8, 4'hB), 1'b0, 1'b0);
        run("R8 E and F codes", mk(30, 4'hE), mk(8, 4'hF), 1'b1, 1'b0);
    endtask

    task automatic t_invalid();
        logic [127:0] a = mk(5, 4'hC);
        a[11:8] = 4'hA;
        @(negedge clk);
        op_a = a; op_b = mk(1, 4'hC); sub = 1'b0; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        check("R9 invalid flag", 128'(invalid), 128'd1);
        check("R9 invalid cond", 128'(cond), 128'h1);
        @(negedge clk);
        check("R1 out_valid drops", 128'(out_valid), 128'd0);
        op_a = mk(1, 4'hC); op_b = {4'hF, 124'd0} | mk(0, 4'hC); in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        check("R9 invalid top digit of B", 128'(invalid), 128'd1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 idle after reset", 128'(out_valid), 128'd0);
        t_like();
        t_unlike();
        t_sub();
        t_pref();
        t_zero();
        t_overflow();
        t_codes();
        t_invalid();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 20000);
        checks++;
        errors++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule